// File: doc/BRIEF.md
# Bit-Serial Adder/Subtractor Sequencer

This block adds or subtracts two unsigned operands of a parameterised width. It has only one single-bit arithmetic cell and uses it again for every bit. The cell works as a full adder or as a full subtractor. Each bit takes two clock cycles. In the first cycle, the fetch cycle, the operand bits for the current position are latched. In the second cycle, the commit cycle, the cell output is written into the result register at that position, and the carry or borrow is written into a one-bit carry store. That stored bit is the carry input for the next position. The first position always starts with a carry of zero.

A caller presents both operands and the mode and pulses `start` while the block is idle. The block captures the operands and the mode at that point and clears the result. It then walks from the least significant bit to the most significant bit. When it is finished it raises `done` for one cycle. At that point `{carry_out, result}` holds the sum, or the difference with its borrow flag.

Top module: `bitserial_addsub`

## Requirements
- R1: While reset is held, and in the cycle after it, `busy`, `done`, `carry_out` and every bit of `result` are 0.
- R2: With `sub_mode`=0, `{carry_out, result}` equals the (WIDTH+1)-bit sum `op_a + op_b` when `done` is high. The first bit has a carry input of 0.
- R3: With `sub_mode`=1, `result` equals `(op_a - op_b) mod 2^WIDTH` and `carry_out` is 1 exactly when `op_a < op_b` (unsigned) when `done` is high. The difference bit is formed the same way as the sum bit; only the carry is replaced by the borrow.
- R4: Bits are produced least significant first. After 2·j rising edges following the accepting edge, `result[j-1:0]` holds its final value and `result[WIDTH-1:j]` is still 0.
- R5: `done` is high only in the single cycle that follows the 2·WIDTH-th rising edge after the accepting edge.
- R6: `start` is accepted on a rising edge where `busy` is 0. `busy` is 1 from the next cycle until `done` is raised, and `busy` is 0 while `done` is 1.
- R7: `start` has no effect while `busy` is 1. The operation neither restarts nor changes its latency or its result.
- R8: The operands and the mode are captured when `start` is accepted. Changing `op_a`, `op_b` or `sub_mode` during an operation does not change its result.
- R9: Accepting `start` clears `result` and `carry_out` to 0 in the following cycle.
- R10: A carry or borrow ripples through every position: all-ones plus 1 gives `result`=0 with `carry_out`=1, and 0 minus 1 gives all-ones with `carry_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; accepted only while idle |
| sub_mode | input | 1 | 0 = add, 1 = subtract (A − B) |
| op_a | input | WIDTH | First operand (minuend) |
| op_b | input | WIDTH | Second operand (subtrahend) |
| result | output | WIDTH | Sum or difference bits |
| carry_out | output | 1 | Final carry, or borrow in subtract mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks the following on every cycle:
- the reset state;
- that acceptance raises `busy` and clears the result;
- that `busy` holds until completion;
- that `done` is a single pulse arriving exactly 2·WIDTH cycles after acceptance;
- that the final `{carry_out, result}` matches a model of the captured operands.

The bench shows what the checker cannot:
- the least-significant-first order of partial results;
- that extra `start` pulses and operand changes during an operation leave it untouched;
- the full-width carry and borrow ripple cases.

// File: rtl/bsas_pkg.sv
package bsas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_COMMIT = 2'd2
  } phase_e;

  function automatic int unsigned idx_width(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/bsas_cell.sv
// Single-bit arithmetic cell, shared by add and subtract.
module bsas_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic sub_i,
  output logic s_o,
  output logic c_o
);
  logic carry_gen;
  logic borrow_gen;

  always_comb begin
    s_o        = a_i ^ b_i ^ c_i;
    carry_gen  = (a_i & (b_i | c_i)) | (b_i & c_i);
    borrow_gen = (~a_i & b_i) | (~a_i & c_i) | (b_i & c_i);
    c_o        = sub_i ? borrow_gen : carry_gen;
  end
endmodule

// File: rtl/bsas_ctrl.sv
// Sequencer: idle -> (fetch, commit) per bit -> idle, with done pulse.
module bsas_ctrl
  import bsas_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDXW  = idx_width(WIDTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            accept,
  output logic            fetch_en,
  output logic            commit_en,
  output logic [IDXW-1:0] bit_idx,
  output logic            busy,
  output logic            done
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(WIDTH - 1);

  phase_e          state_q;
  logic [IDXW-1:0] idx_q;
  logic            done_q;
  logic            last_bit;

  always_comb begin
    accept    = (state_q == ST_IDLE) && start;
    fetch_en  = (state_q == ST_FETCH);
    commit_en = (state_q == ST_COMMIT);
    last_bit  = (idx_q == LAST_IDX);
    bit_idx   = idx_q;
    busy      = (state_q != ST_IDLE);
    done      = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit_en && last_bit;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FETCH;
            idx_q   <= '0;
          end
        end
        ST_FETCH: state_q <= ST_COMMIT;
        ST_COMMIT: begin
          if (last_bit) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_FETCH;
            idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsas_datapath.sv
// Operand capture, bit fetch, result and carry storage around one cell.
module bsas_datapath #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             fetch_en,
  input  logic             commit_en,
  input  logic [IDXW-1:0]  bit_idx,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH-1:0] a_cap_q;
  logic [WIDTH-1:0] b_cap_q;
  logic             mode_q;
  logic             a_bit_q;
  logic             b_bit_q;
  logic [WIDTH-1:0] res_q;
  logic             c_q;
  logic             cell_s;
  logic             cell_c;

  bsas_cell u_cell (
    .a_i  (a_bit_q),
    .b_i  (b_bit_q),
    .c_i  (c_q),
    .sub_i(mode_q),
    .s_o  (cell_s),
    .c_o  (cell_c)
  );

  // Operand capture and per-bit fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap_q <= '0;
      b_cap_q <= '0;
      mode_q  <= 1'b0;
      a_bit_q <= 1'b0;
      b_bit_q <= 1'b0;
    end else begin
      if (accept) begin
        a_cap_q <= op_a;
        b_cap_q <= op_b;
        mode_q  <= sub_mode;
      end
      if (fetch_en) begin
        a_bit_q <= a_cap_q[bit_idx];
        b_bit_q <= b_cap_q[bit_idx];
      end
    end
  end

  // Result bit store and carry/borrow cell
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      c_q   <= 1'b0;
    end else if (accept) begin
      res_q <= '0;
      c_q   <= 1'b0;
    end else if (commit_en) begin
      res_q[bit_idx] <= cell_s;
      c_q            <= cell_c;
    end
  end

  assign result    = res_q;
  assign carry_out = c_q;
endmodule

// File: rtl/bitserial_addsub.sv
module bitserial_addsub
  import bsas_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sub_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             busy,
  output logic             done
);
  localparam int unsigned IDXW = idx_width(WIDTH);

  logic            accept;
  logic            fetch_en;
  logic            commit_en;
  logic [IDXW-1:0] bit_idx;

  bsas_ctrl #(.WIDTH(WIDTH), .IDXW(IDXW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .accept   (accept),
    .fetch_en (fetch_en),
    .commit_en(commit_en),
    .bit_idx  (bit_idx),
    .busy     (busy),
    .done     (done)
  );

  bsas_datapath #(.WIDTH(WIDTH), .IDXW(IDXW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .fetch_en (fetch_en),
    .commit_en(commit_en),
    .bit_idx  (bit_idx),
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_mode (sub_mode),
    .result   (result),
    .carry_out(carry_out)
  );
endmodule

// File: rtl/bsas_checker.sv
module bsas_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sub_mode,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             busy,
  input logic             done
);
  localparam int unsigned CW = $clog2(2 * WIDTH + 1) + 1;
  localparam logic [CW-1:0] LAT = CW'(2 * WIDTH);

  logic [CW-1:0]  busy_cnt;
  logic [WIDTH:0] model_q;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      model_q <= '0;
    end else if (start && !busy) begin
      model_q <= sub_mode ? ({1'b0, op_a} - {1'b0, op_b})
                          : ({1'b0, op_a} + {1'b0, op_b});
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !carry_out && result == '0));

  p_final_value_r2_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> ({carry_out, result} == model_q));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == LAT));

  p_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (result == '0 && !carry_out));
endmodule

bind bitserial_addsub bsas_checker #(.WIDTH(WIDTH)) u_bsas_checker (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .sub_mode (sub_mode),
  .op_a     (op_a),
  .op_b     (op_b),
  .result   (result),
  .carry_out(carry_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_bitserial_addsub.sv
module test_bitserial_addsub;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         busy;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  bitserial_addsub #(.WIDTH(W)) i_bitserial_addsub (
    .clk(clk), .rst(rst), .start(start), .sub_mode(sub_mode),
    .op_a(op_a), .op_b(op_b), .result(result), .carry_out(carry_out),
    .busy(busy), .done(done)
  );

  function automatic logic [W:0] expect_val(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic m);
    return m ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // One operation; disturb pulses start and changes operands mid-run (R7, R8)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                        input bit disturb);
    logic [W:0]   exp;
    logic [W-1:0] mask;
    exp = expect_val(a, b, m);
    @(negedge clk);
    op_a = a; op_b = b; sub_mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 result cleared", {carry_out, result}, '0);
    check("R6 busy after accept", {{W{1'b0}}, busy}, 1);
    for (int j = 1; j <= W; j++) begin
      @(negedge clk);
      if (disturb) begin
        op_a = W'($urandom); op_b = W'($urandom); sub_mode = ~sub_mode; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      mask = W'((1 << j) - 1);
      check("R4 partial lsb-first", {1'b0, result}, {1'b0, exp[W-1:0] & mask});
      if (j < W) begin
        check("R5 no early done", {{W{1'b0}}, done}, 0);
        check("R6 busy mid-run", {{W{1'b0}}, busy}, 1);
      end
    end
    check(disturb ? "R7 R8 R2 R3 final value" : (m ? "R3 difference" : "R2 sum"),
          {carry_out, result}, exp);
    check("R5 done pulse", {{W{1'b0}}, done}, 1);
    check("R6 idle with done", {{W{1'b0}}, busy}, 0);
    @(negedge clk);
    check("R5 done one cycle", {{W{1'b0}}, done}, 0);
    check("R7 no restart", {{W{1'b0}}, busy}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {carry_out, result}, '0);
    check("R1 reset flags", {{(W-1){1'b0}}, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {carry_out, result}, '0);

    run_op(8'd3, 8'd3, 1'b0, 1'b0);        // R2 small sum
    run_op(8'hFF, 8'h01, 1'b0, 1'b0);      // R10 carry ripple
    run_op(8'hFF, 8'hFF, 1'b0, 1'b0);      // R2 max sum
    run_op(8'h00, 8'h01, 1'b1, 1'b0);      // R10 borrow ripple
    run_op(8'd5, 8'd5, 1'b1, 1'b0);        // R3 equal operands
    run_op(8'd200, 8'd100, 1'b1, 1'b0);    // R3 no borrow
    run_op(8'hA5, 8'h5A, 1'b0, 1'b1);      // R7 R8 disturbed
    for (int i = 0; i < 40; i++) begin
      run_op(W'($urandom), W'($urandom), 1'($urandom), bit'($urandom_range(0, 3) == 0));
    end
    finish_run();
  end
endmodule